// File: doc/BRIEF.md
# Burst-8 Write Splitter and Masker

This block turns one incrementing host write burst into the device write commands that a memory with a fixed burst length of eight needs. A device write command always selects an aligned block of eight columns and wraps inside that block. A host burst whose columns run past the end of the block would therefore write back over the start of the same block. The block prevents this by ending the current command at the block edge and issuing a further command at the next block.

Each command carries a block address, a start column inside the block, and an 8-bit beat mask. The mask marks every beat of the eight-beat device burst that must not be written. The memory sequencer behind the block masks those beats on the data-mask pin. The data strobe still runs for all eight beats. Commands leave one at a time through a valid/ready handshake. The request side is closed while a plan is being issued.

Top module: `b8ws_write_splitter`

## Requirements
- R1: After reset, req_ready_o is 1 and cmd_valid_o is 0.
- R2: The column address is the byte address shifted right by req_size_i, where req_size_i is log2 of the beat size in bytes. The block is the column address without its three low bits, and the start column is those three low bits. The first command carries both.
- R3: The beat count is encoded on req_beats_i: 0 means 1 beat, 1 means 4, 2 means 8 and 3 means 16.
- R4: Bit i of cmd_mask_o belongs to the i-th beat sent in the device burst (bit 0 first), and 1 means masked. A burst that fits its block gives one command, with bit i set exactly when i is at or beyond the beat count.
- R5: A burst that crosses the block end gives a first command covering the beats up to the end of the block. Each further command has block + 1 and start column 0.
- R6: A 16-beat burst at column offset 0 gives two unmasked commands. At a nonzero offset it gives three.
- R7: A single-beat access gives a mask of 8'hFE.
- R8: No command wraps. Its unmasked beats form a prefix of the burst, at least one beat is unmasked, and the unmasked count plus the start column is at most 8.
- R9: While cmd_valid_o is 1 and cmd_ready_i is 0, all command outputs hold. cmd_last_o is 1 only on the final command of a plan.
- R10: req_ready_o is 0 while a plan is being issued, and a request presented then is ignored. The cycle after the last command is accepted, cmd_valid_o is 0 and req_ready_o is 1.
- R11: The block address of a follow-on command wraps modulo 2^(ADDR_W-3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Host burst request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_addr_i | input | ADDR_W | Start byte address |
| req_size_i | input | 2 | log2 of beat size in bytes |
| req_beats_i | input | 2 | Beat count code (1/4/8/16) |
| cmd_valid_o | output | 1 | Command valid |
| cmd_ready_i | input | 1 | Command accepted when high with valid |
| cmd_blk_o | output | ADDR_W-3 | Block address of the command |
| cmd_col_o | output | 3 | Start column inside the block |
| cmd_mask_o | output | 8 | Per-beat mask, 1 = masked |
| cmd_last_o | output | 1 | Final command of the plan |

## Verification
The first command appears on the outputs one cycle after the clock edge that accepts the request. Each later command appears one cycle after the edge at which the previous command is taken. req_ready_o returns one cycle after the last command is taken. The bench drives and samples on falling edges. It checks the first command at the falling edge right after acceptance, then checks each later command one falling edge later while cmd_ready_i is held high. For stall cases it checks the held values at every falling edge during which ready stays low.

// File: rtl/b8ws_pkg.sv
package b8ws_pkg;
  localparam int unsigned BURST_LEN = 8;
  localparam int unsigned COL_W     = 3;
  localparam int unsigned CNT_W     = 5;

  typedef enum logic [1:0] {
    BEATS_1  = 2'd0,
    BEATS_4  = 2'd1,
    BEATS_8  = 2'd2,
    BEATS_16 = 2'd3
  } beats_code_e;

  function automatic logic [CNT_W-1:0] beats_of(input logic [1:0] code);
    case (beats_code_e'(code))
      BEATS_1:  return 5'd1;
      BEATS_4:  return 5'd4;
      BEATS_8:  return 5'd8;
      default:  return 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/b8ws_req_decode.sv
module b8ws_req_decode
  import b8ws_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned BLK_W = ADDR_W - COL_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [1:0]        beats_i,
  output logic [BLK_W-1:0]  blk_o,
  output logic [COL_W-1:0]  off_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [ADDR_W-1:0] col;

  assign col   = addr_i >> size_i;
  assign blk_o = col[ADDR_W-1:COL_W];
  assign off_o = col[COL_W-1:0];
  assign cnt_o = beats_of(beats_i);
endmodule

// File: rtl/b8ws_mask_gen.sv
module b8ws_mask_gen
  import b8ws_pkg::*;
(
  input  logic [COL_W-1:0]     off_i,
  input  logic [CNT_W-1:0]     rem_i,
  output logic [COL_W:0]       take_o,
  output logic [BURST_LEN-1:0] mask_o
);
  logic [COL_W:0] room;

  // beats left before the block edge
  assign room   = (COL_W+1)'(BURST_LEN) - {1'b0, off_i};
  assign take_o = (rem_i < {1'b0, room}) ? rem_i[COL_W:0] : room;

  for (genvar g = 0; g < BURST_LEN; g++) begin : g_beat
    assign mask_o[g] = (take_o <= (COL_W+1)'(g));
  end
endmodule

// File: rtl/b8ws_cmd_seq.sv
module b8ws_cmd_seq
  import b8ws_pkg::*;
#(
  parameter int unsigned BLK_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [COL_W-1:0] off_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [COL_W:0]   take_i,
  input  logic             fire_i,
  output logic             busy_o,
  output logic             last_o,
  output logic [BLK_W-1:0] blk_o,
  output logic [COL_W-1:0] off_o,
  output logic [CNT_W-1:0] rem_o
);
  logic             busy_q;
  logic [BLK_W-1:0] blk_q;
  logic [COL_W-1:0] off_q;
  logic [CNT_W-1:0] rem_q;

  assign last_o = ({1'b0, take_i} == rem_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      blk_q  <= '0;
      off_q  <= '0;
      rem_q  <= '0;
    end else if (load_i && !busy_q) begin
      busy_q <= 1'b1;
      blk_q  <= blk_i;
      off_q  <= off_i;
      rem_q  <= cnt_i;
    end else if (fire_i && busy_q) begin
      if (last_o) begin
        busy_q <= 1'b0;
      end else begin
        blk_q <= blk_q + BLK_W'(1);
        off_q <= '0;
        rem_q <= rem_q - {1'b0, take_i};
      end
    end
  end

  assign busy_o = busy_q;
  assign blk_o  = blk_q;
  assign off_o  = off_q;
  assign rem_o  = rem_q;

  a_r10_rem_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (rem_q != '0));
endmodule

// File: rtl/b8ws_write_splitter.sv
module b8ws_write_splitter
  import b8ws_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned BLK_W = ADDR_W - COL_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [1:0]           req_size_i,
  input  logic [1:0]           req_beats_i,
  output logic                 cmd_valid_o,
  input  logic                 cmd_ready_i,
  output logic [BLK_W-1:0]     cmd_blk_o,
  output logic [COL_W-1:0]     cmd_col_o,
  output logic [BURST_LEN-1:0] cmd_mask_o,
  output logic                 cmd_last_o
);
  logic [BLK_W-1:0] dec_blk;
  logic [COL_W-1:0] dec_off;
  logic [CNT_W-1:0] dec_cnt;
  logic [CNT_W-1:0] rem;
  logic [COL_W:0]   take;
  logic             busy;

  b8ws_req_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i  (req_addr_i),
    .size_i  (req_size_i),
    .beats_i (req_beats_i),
    .blk_o   (dec_blk),
    .off_o   (dec_off),
    .cnt_o   (dec_cnt)
  );

  b8ws_cmd_seq #(.BLK_W(BLK_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (req_valid_i),
    .blk_i   (dec_blk),
    .off_i   (dec_off),
    .cnt_i   (dec_cnt),
    .take_i  (take),
    .fire_i  (cmd_ready_i),
    .busy_o  (busy),
    .last_o  (cmd_last_o),
    .blk_o   (cmd_blk_o),
    .off_o   (cmd_col_o),
    .rem_o   (rem)
  );

  b8ws_mask_gen u_mask (
    .off_i  (cmd_col_o),
    .rem_i  (rem),
    .take_o (take),
    .mask_o (cmd_mask_o)
  );

  assign req_ready_o = !busy;
  assign cmd_valid_o = busy;

  logic [BURST_LEN-1:0] unm;
  assign unm = ~cmd_mask_o;

  a_r2_first_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=>
      (cmd_valid_o && cmd_blk_o == $past(dec_blk) && cmd_col_o == $past(dec_off)));

  // R5 and R11: next block, modulo block width
  a_r5_next_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_ready_i && !cmd_last_o) |=>
      (cmd_valid_o && cmd_col_o == '0 && cmd_blk_o == $past(cmd_blk_o) + BLK_W'(1)));

  a_r8_prefix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (((unm & (unm + 8'd1)) == '0) && (unm != '0) &&
                     ($countones(unm) + int'(cmd_col_o) <= BURST_LEN)));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=>
      (cmd_valid_o && $stable(cmd_blk_o) && $stable(cmd_col_o) &&
       $stable(cmd_mask_o) && $stable(cmd_last_o)));

  a_r10_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_ready_i && cmd_last_o) |=> (!cmd_valid_o && req_ready_o));
endmodule

// File: tb/b8ws_write_splitter_tb_top.sv
module b8ws_write_splitter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int BLK_W = ADDR_W - 3;
  localparam int NVEC = 10;
  localparam int WATCHDOG = 20000;

  typedef struct packed {
    logic [7:0]             tag;
    logic [15:0]            addr;
    logic [1:0]             size;
    logic [1:0]             code;
    logic [1:0]             ncmd;
    logic [0:2][BLK_W-1:0]  blk;
    logic [0:2][2:0]        col;
    logic [0:2][7:0]        mask;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    // R7 single beat
    '{8'd7,  16'h0000, 2'd2, 2'd0, 2'd1, '{13'h0, 13'h0, 13'h0},    '{3'd0, 3'd0, 3'd0}, '{8'hFE, 8'h00, 8'h00}},
    // R4 fits in block
    '{8'd4,  16'h000C, 2'd2, 2'd1, 2'd1, '{13'h0, 13'h0, 13'h0},    '{3'd3, 3'd0, 3'd0}, '{8'hF0, 8'h00, 8'h00}},
    // R5 crossing
    '{8'd5,  16'h0018, 2'd2, 2'd1, 2'd2, '{13'h0, 13'h1, 13'h0},    '{3'd6, 3'd0, 3'd0}, '{8'hFC, 8'hFC, 8'h00}},
    // R6 aligned 16
    '{8'd6,  16'h0040, 2'd2, 2'd3, 2'd2, '{13'h2, 13'h3, 13'h0},    '{3'd0, 3'd0, 3'd0}, '{8'h00, 8'h00, 8'h00}},
    // R6 unaligned 16
    '{8'd6,  16'h004C, 2'd2, 2'd3, 2'd3, '{13'h2, 13'h3, 13'h4},    '{3'd3, 3'd0, 3'd0}, '{8'hE0, 8'h00, 8'hF8}},
    // R2 halfword beats, R3 eight beats
    '{8'd2,  16'h0006, 2'd1, 2'd2, 2'd2, '{13'h0, 13'h1, 13'h0},    '{3'd3, 3'd0, 3'd0}, '{8'hE0, 8'hF8, 8'h00}},
    // R8 start at last column
    '{8'd8,  16'h0107, 2'd0, 2'd2, 2'd2, '{13'h20, 13'h21, 13'h0},  '{3'd7, 3'd0, 3'd0}, '{8'hFE, 8'h80, 8'h00}},
    // R11 block wrap
    '{8'd11, 16'hFFFE, 2'd0, 2'd1, 2'd2, '{13'h1FFF, 13'h0, 13'h0}, '{3'd6, 3'd0, 3'd0}, '{8'hFC, 8'hFC, 8'h00}},
    // R3 aligned eight beats
    '{8'd3,  16'h0020, 2'd2, 2'd2, 2'd1, '{13'h1, 13'h0, 13'h0},    '{3'd0, 3'd0, 3'd0}, '{8'h00, 8'h00, 8'h00}},
    // R2 doubleword beats
    '{8'd2,  16'h001C, 2'd3, 2'd0, 2'd1, '{13'h0, 13'h0, 13'h0},    '{3'd3, 3'd0, 3'd0}, '{8'hFE, 8'h00, 8'h00}}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_size = '0;
  logic [1:0]        req_beats = '0;
  logic              cmd_valid;
  logic              cmd_ready = 1'b0;
  logic [BLK_W-1:0]  cmd_blk;
  logic [2:0]        cmd_col;
  logic [7:0]        cmd_mask;
  logic              cmd_last;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  b8ws_write_splitter #(.ADDR_W(ADDR_W)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_ready_o (req_ready),
    .req_addr_i  (req_addr),
    .req_size_i  (req_size),
    .req_beats_i (req_beats),
    .cmd_valid_o (cmd_valid),
    .cmd_ready_i (cmd_ready),
    .cmd_blk_o   (cmd_blk),
    .cmd_col_o   (cmd_col),
    .cmd_mask_o  (cmd_mask),
    .cmd_last_o  (cmd_last)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack_cmd(input logic v, input logic [BLK_W-1:0] b,
                                           input logic [2:0] c, input logic [7:0] m,
                                           input logic l);
    return {7'd0, v, l, b, c, m};
  endfunction

  task automatic send(input logic [15:0] a, input logic [1:0] s, input logic [1:0] c);
    @(negedge clk);
    req_addr = a; req_size = s; req_beats = c; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_vec(input int i, input bit stall, input bit intrude);
    string tag;
    tag = $sformatf("R%0d vec%0d", VECS[i].tag, i);
    send(VECS[i].addr, VECS[i].size, VECS[i].code);
    for (int k = 0; k < int'(VECS[i].ncmd); k++) begin
      logic [31:0] exp;
      exp = pack_cmd(1'b1, VECS[i].blk[k], VECS[i].col[k], VECS[i].mask[k],
                     k == int'(VECS[i].ncmd) - 1);
      check(tag, pack_cmd(cmd_valid, cmd_blk, cmd_col, cmd_mask, cmd_last), exp);
      if (stall && k == 0) begin
        cmd_ready = 1'b0;
        for (int w = 0; w < 3; w++) begin
          @(negedge clk);
          check("R9 stall hold", pack_cmd(cmd_valid, cmd_blk, cmd_col, cmd_mask, cmd_last), exp);
        end
      end
      if (intrude) begin
        req_addr = 16'h0000; req_size = 2'd0; req_beats = 2'd0; req_valid = 1'b1;
        check("R10 ready low while busy", {31'd0, req_ready}, 32'd0);
      end
      cmd_ready = 1'b1;
      @(negedge clk);
    end
    req_valid = 1'b0;
    cmd_ready = 1'b0;
    check({tag, " R10 idle after plan"}, {30'd0, cmd_valid, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset idle", {30'd0, cmd_valid, req_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {30'd0, cmd_valid, req_ready}, 32'd1);

    for (int i = 0; i < NVEC; i++) run_vec(i, 1'b0, 1'b0);

    // R9 stall on a three-command plan
    run_vec(4, 1'b1, 1'b0);
    // R10 request during a plan is ignored
    run_vec(2, 1'b0, 1'b1);
    @(negedge clk);
    check("R10 no extra command", {31'd0, cmd_valid}, 32'd0);
    // plan after the intrusion is still correct
    run_vec(6, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule